// File: doc/BRIEF.md
# Critical Section Request Buffer

This block sits between a group of small cores and one shared accelerator core that runs contended critical sections on their behalf. A small core that reaches a critical section posts a request with the lock address, the entry program counter of the section, its stack pointer and its own core index. The buffer queues the request. It hands the oldest waiting request to the accelerator once the accelerator is idle. When the accelerator reports that the section has finished, the buffer sends a completion pulse back to the core that posted that request and to no other.

The buffer also watches for false serialization, where a request for one lock sits behind requests for unrelated locks. A table of small saturating counters is selected by the low bits of the lock address. A counter rises each time a request for its lock is queued behind other locks only, and it falls when the request is queued behind an entry for the same lock. Once a counter reaches its threshold, any further request that selects it is turned away in the same cycle with a run-locally pulse to the requester, and the requester executes the section itself.

Top module: `crit_req_buffer`

## Requirements
- R1: A dispatched request presents on the accelerator side exactly the lock address, program counter, stack pointer and core index it was posted with.
- R2: Requests are dispatched oldest first. Only one request is in service at a time: after a dispatch handshake (acc_valid and acc_ready both high), acc_valid stays low until acc_done has been seen.
- R3: The buffer holds NCORE requests. With NCORE entries queued, req_ready is low unless a dispatch happens in the same cycle, and in that case a new request is accepted in that cycle.
- R4: acc_done while a request is in service raises, in that same cycle, only bit k of rsp_done, where k is the core index of the request in service. acc_done while nothing is in service raises no bit.
- R5: The counter is selected by the low CTR_SEL_W bits of the lock address. It increments by one when a request is queued and at least one request remains ahead of it, none of them for the same full lock address. It does not change when nothing remains ahead (an entry dispatched in the same cycle does not count as ahead).
- R6: The counter decrements by one when a request is queued behind at least one entry with the same full lock address. It never goes below 0 and never above 15.
- R7: When an accepted request selects a counter at or above 8, bit k of rsp_local pulses in that cycle for the requesting core k, and the request is not queued.
- R8: Reset empties the buffer, clears the in-service state and clears every counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A small core posts a request |
| req_ready | output | 1 | Buffer can take a request this cycle |
| req_lock | input | LOCK_W | Lock address of the request |
| req_pc | input | PC_W | Entry program counter of the critical section |
| req_sp | input | SP_W | Stack pointer of the requester |
| req_core | input | $clog2(NCORE) | Index of the requesting core |
| acc_valid | output | 1 | A request is offered to the accelerator |
| acc_ready | input | 1 | Accelerator takes the offered request |
| acc_lock | output | LOCK_W | Lock address of the offered request |
| acc_pc | output | PC_W | Program counter of the offered request |
| acc_sp | output | SP_W | Stack pointer of the offered request |
| acc_core | output | $clog2(NCORE) | Requester of the offered request |
| acc_done | input | 1 | Accelerator finished the section in service |
| rsp_done | output | NCORE | One-hot completion pulse to the requester |
| rsp_local | output | NCORE | One-hot run-locally pulse to a turned-away requester |

## Verification
On every cycle the assertions check that occupancy never exceeds the capacity, that a dispatch is followed by a cycle with no offer, that completion pulses are one-hot and appear only with acc_done, and that a turned-away request leaves occupancy unchanged. Oldest-first order, correct routing of each completion and the exact round in which a lock's counter crosses its threshold depend on request history. Only the bench's reference model and its scenarios can show these: alternating-lock rounds, same-lock rounds that test the floor, and a full buffer that is refilled in the same cycle as a dispatch.

// File: rtl/crit_req_buffer.sv
module crit_req_buffer #(
  parameter int NCORE     = 4,
  parameter int LOCK_W    = 16,
  parameter int PC_W      = 16,
  parameter int SP_W      = 16,
  parameter int CTR_SEL_W = 3,
  parameter int CTR_W     = 4,
  parameter int THRESH    = 8,
  localparam int CORE_W   = (NCORE > 1) ? $clog2(NCORE) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LOCK_W-1:0] req_lock,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [SP_W-1:0]   req_sp,
  input  logic [CORE_W-1:0] req_core,
  output logic              acc_valid,
  input  logic              acc_ready,
  output logic [LOCK_W-1:0] acc_lock,
  output logic [PC_W-1:0]   acc_pc,
  output logic [SP_W-1:0]   acc_sp,
  output logic [CORE_W-1:0] acc_core,
  input  logic              acc_done,
  output logic [NCORE-1:0]  rsp_done,
  output logic [NCORE-1:0]  rsp_local
);
  localparam int NCTR  = 1 << CTR_SEL_W;
  localparam int CMAX  = (1 << CTR_W) - 1;
  localparam int CNT_W = $clog2(NCORE + 1);

  logic [LOCK_W-1:0] q_lock [NCORE];
  logic [PC_W-1:0]   q_pc   [NCORE];
  logic [SP_W-1:0]   q_sp   [NCORE];
  logic [CORE_W-1:0] q_core [NCORE];
  logic [CTR_W-1:0]  ctr    [NCTR];

  logic [CORE_W-1:0] rd_ptr, wr_ptr, cur_core;
  logic [CNT_W-1:0]  count;
  logic              busy;
  logic              pop, hit, push, mark_local, same_ahead, any_ahead;
  logic [CTR_SEL_W-1:0] ctr_sel;

  function automatic logic [CORE_W-1:0] wrap_inc(input logic [CORE_W-1:0] p);
    return (int'(p) == NCORE - 1) ? '0 : p + 1'b1;
  endfunction

  assign acc_valid  = (count != '0) && !busy;
  assign pop        = acc_valid && acc_ready;
  assign req_ready  = (int'(count) < NCORE) || pop;
  assign hit        = req_valid && req_ready;
  assign ctr_sel    = req_lock[CTR_SEL_W-1:0];
  assign mark_local = int'(ctr[ctr_sel]) >= THRESH;
  assign push       = hit && !mark_local;

  assign acc_lock = q_lock[rd_ptr];
  assign acc_pc   = q_pc[rd_ptr];
  assign acc_sp   = q_sp[rd_ptr];
  assign acc_core = q_core[rd_ptr];

  assign rsp_done  = (busy && acc_done) ? (NCORE'(1) << cur_core) : '0;
  assign rsp_local = (hit && mark_local) ? (NCORE'(1) << req_core) : '0;

  always_comb begin
    same_ahead = 1'b0;
    any_ahead  = 1'b0;
    for (int k = 0; k < NCORE; k++) begin
      int pos;
      pos = int'(rd_ptr) + k;
      if (pos >= NCORE) pos = pos - NCORE;
      if (k < int'(count) && !(pop && k == 0)) begin
        any_ahead = 1'b1;
        if (q_lock[CORE_W'(pos)] == req_lock) same_ahead = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      busy     <= 1'b0;
      cur_core <= '0;
    end else begin
      if (push) begin
        q_lock[wr_ptr] <= req_lock;
        q_pc[wr_ptr]   <= req_pc;
        q_sp[wr_ptr]   <= req_sp;
        q_core[wr_ptr] <= req_core;
        wr_ptr         <= wrap_inc(wr_ptr);
      end
      if (pop) begin
        rd_ptr   <= wrap_inc(rd_ptr);
        busy     <= 1'b1;
        cur_core <= q_core[rd_ptr];
      end else if (acc_done) begin
        busy <= 1'b0;
      end
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCTR; i++) ctr[i] <= '0;
    end else if (push) begin
      if (same_ahead) begin
        if (ctr[ctr_sel] != '0) ctr[ctr_sel] <= ctr[ctr_sel] - 1'b1;
      end else if (any_ahead) begin
        if (int'(ctr[ctr_sel]) < CMAX) ctr[ctr_sel] <= ctr[ctr_sel] + 1'b1;
      end
    end
  end

  // R3
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= NCORE);
  // R2
  single_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> !acc_valid);
  // R4
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_done));
  // R4
  done_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done != '0) |-> acc_done);
  // R7
  local_not_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_local != '0 && !pop) |=> $stable(count));
  // R7
  local_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_local));
endmodule

// File: tb/tb_crit_req_buffer.sv
module tb_crit_req_buffer;
  localparam int NCORE = 4;
  localparam int CW = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, acc_ready = 0, acc_done = 0;
  logic [15:0] req_lock = 0, req_pc = 0, req_sp = 0;
  logic [CW-1:0] req_core = 0;
  logic req_ready, acc_valid;
  logic [15:0] acc_lock, acc_pc, acc_sp;
  logic [CW-1:0] acc_core;
  logic [NCORE-1:0] rsp_done, rsp_local;

  int checks = 0, errors = 0;

  crit_req_buffer #(.NCORE(NCORE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lock(req_lock), .req_pc(req_pc), .req_sp(req_sp), .req_core(req_core),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_lock(acc_lock),
    .acc_pc(acc_pc), .acc_sp(acc_sp), .acc_core(acc_core), .acc_done(acc_done),
    .rsp_done(rsp_done), .rsp_local(rsp_local));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  int mq_lock[$], mq_pc[$], mq_sp[$], mq_core[$];
  int mctr[8];
  bit mbusy;
  int mcur;

  always @(negedge clk) begin
    if (!rst_n) begin
      mq_lock.delete(); mq_pc.delete(); mq_sp.delete(); mq_core.delete();
      foreach (mctr[i]) mctr[i] = 0;
      mbusy = 0; mcur = 0;
    end else begin
      bit ev, epop, erdy, ehit, emark, same, any;
      int eloc, edone, sel;
      ev    = mq_lock.size() > 0 && !mbusy;
      epop  = ev && acc_ready;
      erdy  = mq_lock.size() < NCORE || epop;
      ehit  = req_valid && erdy;
      sel   = int'(req_lock) % 8;
      emark = mctr[sel] >= 8;
      eloc  = (ehit && emark) ? (1 << req_core) : 0;
      edone = (mbusy && acc_done) ? (1 << mcur) : 0;
      chk(acc_valid == ev, "R2 acc_valid", acc_valid, ev);
      chk(req_ready == erdy, "R3 req_ready", req_ready, erdy);
      if (ev) begin
        chk(acc_lock == 16'(mq_lock[0]), "R1 acc_lock", acc_lock, mq_lock[0]);
        chk(acc_pc == 16'(mq_pc[0]), "R1 acc_pc", acc_pc, mq_pc[0]);
        chk(acc_sp == 16'(mq_sp[0]), "R1 acc_sp", acc_sp, mq_sp[0]);
        chk(int'(acc_core) == mq_core[0], "R2 acc_core order", acc_core, mq_core[0]);
      end
      chk(int'(rsp_done) == edone, "R4 rsp_done", rsp_done, edone);
      chk(int'(rsp_local) == eloc, "R7 rsp_local", rsp_local, eloc);
      same = 0; any = 0;
      for (int k = (epop ? 1 : 0); k < mq_lock.size(); k++) begin
        any = 1;
        if (mq_lock[k] == int'(req_lock)) same = 1;
      end
      if (epop) begin
        mbusy = 1; mcur = mq_core[0];
        void'(mq_lock.pop_front()); void'(mq_pc.pop_front());
        void'(mq_sp.pop_front()); void'(mq_core.pop_front());
      end else if (acc_done) mbusy = 0;
      if (ehit && !emark) begin
        if (same) begin if (mctr[sel] > 0) mctr[sel]--; end
        else if (any) begin if (mctr[sel] < 15) mctr[sel]++; end
        mq_lock.push_back(int'(req_lock)); mq_pc.push_back(int'(req_pc));
        mq_sp.push_back(int'(req_sp)); mq_core.push_back(int'(req_core));
      end
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic post(input int lock, input int core);
    req_valid = 1; req_lock = 16'(lock); req_core = CW'(core);
    req_pc = 16'(lock + 16'h0100 + core); req_sp = 16'(16'hF000 - lock + core);
  endtask

  task automatic drain();
    req_valid = 0; acc_ready = 1; acc_done = 1;
    repeat (10) step();
    acc_ready = 0; acc_done = 0;
  endtask

  task automatic round(input int la, input int lb, input bit exp_rej, input string tag);
    post(la, 0); step();
    post(lb, 1);
    @(negedge clk);
    chk(rsp_local == (exp_rej ? 4'b0010 : 4'b0000), tag, rsp_local, exp_rej ? 2 : 0);
    step();
    drain();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R8 reset state
    chk(req_ready == 1 && acc_valid == 0 && rsp_done == 0 && rsp_local == 0,
        "R8 reset", {req_ready, acc_valid}, 2'b10);
    step();

    // R4: done while idle has no effect
    acc_done = 1; @(negedge clk);
    chk(rsp_done == 0, "R4 idle done", rsp_done, 0);
    step(); acc_done = 0;

    // R3: fill with four different locks, then full and same-cycle refill
    post(16'h5005, 2); step();
    post(16'h6006, 0); step();
    post(16'h7007, 3); step();
    post(16'h8008, 1); step();
    post(16'h500D, 3);
    @(negedge clk);
    chk(req_ready == 0, "R3 full", req_ready, 0);
    step();
    acc_ready = 1;
    @(negedge clk);
    chk(req_ready == 1, "R3 refill same cycle", req_ready, 1);
    chk(acc_core == 2, "R2 oldest first", acc_core, 2);
    step();
    req_valid = 0; acc_ready = 0;
    acc_done = 1;
    @(negedge clk);
    chk(rsp_done == 4'b0100, "R4 routed to core 2", rsp_done, 4);
    step(); acc_done = 0;
    drain();

    // R5: lock 1001 behind 2002 each round; rejected on the ninth round
    for (int r = 0; r < 9; r++) round(16'h2002, 16'h1001, r == 8, "R5 rise to threshold");

    // R6: floor at 0, then rises, one same-lock round lowers it
    for (int r = 0; r < 3; r++) round(16'h3003, 16'h3003, 0, "R6 floor");
    for (int r = 0; r < 7; r++) round(16'h4004, 16'h3003, 0, "R6 rise");
    round(16'h3003, 16'h3003, 0, "R6 decrement");
    round(16'h4004, 16'h3003, 0, "R6 rise after decrement");
    round(16'h4004, 16'h3003, 0, "R6 reach threshold");
    round(16'h4004, 16'h3003, 1, "R6 R7 run locally");

    // R8: reset clears counters
    rst_n = 0; step(); rst_n = 1;
    post(16'h1001, 2);
    @(negedge clk);
    chk(rsp_local == 0, "R8 counters cleared", rsp_local, 0);
    step();
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule